// File: doc/BRIEF.md
# Translation Context and Mode Selector

This block is the combinational front end of a radix address translation unit, followed by one output register. For each request it takes a 64-bit effective address, an access kind and the machine state flags. It then decides how the access proceeds. There are three possible paths:

- **Real-mode bypass.** The block forms the real address at once and grants full permission.
- **Segment fault.** The quadrant is not legal in the current state.
- **Translation.** The block selects the partition and process identifiers that the page walker needs.

Before a translation it also checks that the selected process identifier indexes an entry inside the process table. A process identifier outside the table produces a no-entry fault instead of a translation.

Requests arrive on a valid/ready channel and results leave on a second valid/ready channel toward the walker. The block holds one result. A result is held unchanged while the walker applies back-pressure. A new request is accepted in the same cycle that the held result is taken, so a fully ready walker sees one result per clock. The state flags and the identifier, offset and table-size registers are plain level inputs. They are sampled together with the request.

Top module: `xlat_ctx_sel`

## Requirements
- R1: An access kind of 3 (kinds: 0 read, 1 write, 2 fetch) yields the configuration-error outcome (bit 4), ahead of every other outcome.
- R2: Bypass (outcome bit 0) is chosen when hypervisor state or the virtual-hypervisor flag is set and relocation is off for the access: the instruction relocation flag for fetches, the data relocation flag for reads and writes.
- R3: On bypass the real address is the effective address with bits 63:60 cleared. The offset register is ORed in when bit 63 of the address is clear and either hypervisor state is set or no hypervisor mode is implemented.
- R4: A bypass result carries permission 3'b111 (bit 0 read, bit 1 write, bit 2 execute); every other outcome carries 3'b000.
- R5: In hypervisor state the quadrant (address bits 63:62) selects the partition and process identifiers as follows:
  - quadrant 0: partition 0 and the process register;
  - quadrant 1: the partition register and the process register;
  - quadrant 2: the partition register and process 0;
  - quadrant 3: partition 0 and process 0.
- R6: Outside hypervisor state the selection is as follows:
  - quadrant 0: the partition register and the process register;
  - quadrant 3: the partition register and process 0.
- R7: Outside hypervisor state, quadrants 1 and 2 give the segment-fault outcome (bit 1). The fetch flag is set for a fetch; the fault address is the effective address for reads and writes and zero for fetches.
- R8: If the selected process identifier times 16 is not below 2^(table-size field + 12), the no-entry outcome (bit 2) is given instead of translation (bit 3). It uses the same fault-address rule as R7.
- R9: Exactly one outcome bit is set in every valid result; priority is configuration error, bypass, segment fault, no-entry, translate. Translation results carry the selected identifiers; all others carry zero identifiers.
- R10: The request ready output equals no held result or result ready. A held result stays valid and unchanged while result ready is low.
- R11: After reset no result is valid and the request side is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 illegal |
| st_hv | input | 1 | Hypervisor state |
| st_ir | input | 1 | Instruction relocation enable |
| st_dr | input | 1 | Data relocation enable |
| st_vhyp | input | 1 | Virtual hypervisor active |
| cfg_hv_impl | input | 1 | Hypervisor mode implemented |
| reg_part | input | PARTW | Partition identifier register |
| reg_proc | input | PROCW | Process identifier register |
| reg_rmo | input | 64 | Real-mode offset register |
| cfg_prts | input | 5 | Process table size field |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Walker takes the result |
| rsp_outcome | output | 5 | One-hot: 0 bypass, 1 segment fault, 2 no-entry, 3 translate, 4 config error |
| rsp_raddr | output | 64 | Real address on bypass, else zero |
| rsp_perm | output | 3 | Granted read/write/execute |
| rsp_part | output | PARTW | Selected partition identifier |
| rsp_proc | output | PROCW | Selected process identifier |
| rsp_ifetch | output | 1 | Fault belongs to a fetch |
| rsp_fault_addr | output | 64 | Recorded fault address |

## Verification
A wrong quadrant decode shows up at the walker one cycle after acceptance, as an outcome or identifier mismatch. Every quadrant is driven in both states to expose it. An error in the bound arithmetic appears only at the exact table edge, so the process identifier is stepped to one entry below and exactly at the table size. A broken hold register shows as a result that changes or disappears during back-pressure within the next cycle. Reversed priority shows when two conditions hold at once, for example bypass together with an illegal quadrant.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_FX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_kind_e;

  localparam int OC_W     = 5;
  localparam int OC_BYP   = 0;
  localparam int OC_SEG   = 1;
  localparam int OC_NOENT = 2;
  localparam int OC_XLT   = 3;
  localparam int OC_CFG   = 4;
endpackage

// File: rtl/xcs_quadrant.sv
module xcs_quadrant #(
  parameter int PARTW = 12,
  parameter int PROCW = 20
) (
  input  logic [1:0]       quad,
  input  logic             hv,
  input  logic [PARTW-1:0] part_reg,
  input  logic [PROCW-1:0] proc_reg,
  output logic [PARTW-1:0] part_sel,
  output logic [PROCW-1:0] proc_sel,
  output logic             legal
);
  always_comb begin
    part_sel = '0;
    proc_sel = '0;
    legal    = 1'b1;
    if (hv) begin
      unique case (quad)
        2'd0: proc_sel = proc_reg;
        2'd1: begin part_sel = part_reg; proc_sel = proc_reg; end
        2'd2: part_sel = part_reg;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin part_sel = part_reg; proc_sel = proc_reg; end
        2'd3: part_sel = part_reg;
        default: legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xcs_realmode.sv
module xcs_realmode #(
  parameter int AW      = 64,
  parameter int CLRBITS = 4
) (
  input  logic [AW-1:0] ea,
  input  logic          is_fetch,
  input  logic          hv,
  input  logic          vhyp,
  input  logic          hv_impl,
  input  logic          ir,
  input  logic          dr,
  input  logic [AW-1:0] rmo,
  output logic          bypass,
  output logic [AW-1:0] raddr
);
  localparam logic [AW-1:0] KEEP_MASK = {{CLRBITS{1'b0}}, {(AW-CLRBITS){1'b1}}};

  logic reloc_on;
  logic add_rmo;

  assign reloc_on = is_fetch ? ir : dr;
  assign bypass   = (hv | vhyp) & ~reloc_on;
  assign add_rmo  = (hv | ~hv_impl) & ~ea[AW-1];
  assign raddr    = (ea & KEEP_MASK) | (add_rmo ? rmo : '0);
endmodule

// File: rtl/xcs_prtb_bound.sv
module xcs_prtb_bound #(
  parameter int PROCW   = 20,
  parameter int ENT_LG  = 4,
  parameter int SZW     = 5,
  parameter int BASE_LG = 12
) (
  input  logic [PROCW-1:0] proc_id,
  input  logic [SZW-1:0]   size_fld,
  output logic             fits
);
  localparam int OW  = PROCW + ENT_LG;
  localparam int SHW = SZW + 2;

  logic [OW-1:0]  byte_off;
  logic [SHW-1:0] size_lg;

  assign byte_off = {proc_id, {ENT_LG{1'b0}}};
  assign size_lg  = SHW'(size_fld) + SHW'(BASE_LG);
  assign fits     = ((byte_off >> size_lg) == '0);
endmodule

// File: rtl/xlat_ctx_sel.sv
module xlat_ctx_sel
  import xcs_pkg::*;
#(
  parameter int PARTW = 12,
  parameter int PROCW = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [63:0]         req_ea,
  input  logic [1:0]          req_kind,
  input  logic                st_hv,
  input  logic                st_ir,
  input  logic                st_dr,
  input  logic                st_vhyp,
  input  logic                cfg_hv_impl,
  input  logic [PARTW-1:0]    reg_part,
  input  logic [PROCW-1:0]    reg_proc,
  input  logic [63:0]         reg_rmo,
  input  logic [4:0]          cfg_prts,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [OC_W-1:0]     rsp_outcome,
  output logic [63:0]         rsp_raddr,
  output logic [2:0]          rsp_perm,
  output logic [PARTW-1:0]    rsp_part,
  output logic [PROCW-1:0]    rsp_proc,
  output logic                rsp_ifetch,
  output logic [63:0]         rsp_fault_addr
);
  localparam int AW = 64;

  logic             is_fetch, kind_bad;
  logic             byp;
  logic [AW-1:0]    byp_addr;
  logic [PARTW-1:0] q_part;
  logic [PROCW-1:0] q_proc;
  logic             q_legal;
  logic             tbl_fits;

  assign kind_bad = (req_kind == ACC_BAD);
  assign is_fetch = (req_kind == ACC_FX);

  xcs_realmode #(.AW(AW), .CLRBITS(4)) u_rm (
    .ea(req_ea), .is_fetch(is_fetch), .hv(st_hv), .vhyp(st_vhyp),
    .hv_impl(cfg_hv_impl), .ir(st_ir), .dr(st_dr), .rmo(reg_rmo),
    .bypass(byp), .raddr(byp_addr)
  );

  xcs_quadrant #(.PARTW(PARTW), .PROCW(PROCW)) u_quad (
    .quad(req_ea[AW-1:AW-2]), .hv(st_hv), .part_reg(reg_part),
    .proc_reg(reg_proc), .part_sel(q_part), .proc_sel(q_proc),
    .legal(q_legal)
  );

  xcs_prtb_bound #(.PROCW(PROCW), .ENT_LG(4), .SZW(5), .BASE_LG(12)) u_bound (
    .proc_id(q_proc), .size_fld(cfg_prts), .fits(tbl_fits)
  );

  // next-result formation, priority cfg > bypass > seg > noent > translate
  logic [OC_W-1:0]  n_oc;
  logic [AW-1:0]    n_raddr, n_faddr;
  logic [2:0]       n_perm;
  logic [PARTW-1:0] n_part;
  logic [PROCW-1:0] n_proc;
  logic             n_ifetch;

  always_comb begin
    n_oc     = '0;
    n_raddr  = '0;
    n_faddr  = '0;
    n_perm   = 3'b000;
    n_part   = '0;
    n_proc   = '0;
    n_ifetch = 1'b0;
    if (kind_bad) begin
      n_oc[OC_CFG] = 1'b1;
    end else if (byp) begin
      n_oc[OC_BYP] = 1'b1;
      n_raddr      = byp_addr;
      n_perm       = 3'b111;
    end else if (!q_legal || !tbl_fits) begin
      if (!q_legal) n_oc[OC_SEG]   = 1'b1;
      else          n_oc[OC_NOENT] = 1'b1;
      n_ifetch = is_fetch;
      n_faddr  = is_fetch ? '0 : req_ea;
    end else begin
      n_oc[OC_XLT] = 1'b1;
      n_part       = q_part;
      n_proc       = q_proc;
    end
  end

  // single result slot toward the walker
  logic load;
  assign req_ready = ~rsp_valid | rsp_ready;
  assign load      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_outcome    <= '0;
      rsp_raddr      <= '0;
      rsp_perm       <= '0;
      rsp_part       <= '0;
      rsp_proc       <= '0;
      rsp_ifetch     <= 1'b0;
      rsp_fault_addr <= '0;
    end else begin
      if (load) begin
        rsp_valid      <= 1'b1;
        rsp_outcome    <= n_oc;
        rsp_raddr      <= n_raddr;
        rsp_perm       <= n_perm;
        rsp_part       <= n_part;
        rsp_proc       <= n_proc;
        rsp_ifetch     <= n_ifetch;
        rsp_fault_addr <= n_faddr;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_outcome)
                                   && $stable(rsp_raddr) && $stable(rsp_proc)));

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_outcome) == 1));

  a_r4_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_outcome[OC_BYP]) |-> (rsp_perm == 3'b111));

  a_r5_hv_no_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && st_hv) |=> !rsp_outcome[OC_SEG]);

  a_r1_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd3) |=> rsp_outcome[OC_CFG]);

  a_r7_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ifetch) |-> (rsp_fault_addr == 64'd0));
endmodule

// File: tb/sim_xlat_ctx_sel.sv
`timescale 1ns/1ps
module sim_xlat_ctx_sel;
  localparam int PARTW = 12;
  localparam int PROCW = 20;
  localparam logic [4:0] O_BYP = 5'b00001, O_SEG = 5'b00010,
                         O_NOE = 5'b00100, O_XLT = 5'b01000, O_CFG = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1;
  logic [63:0] req_ea = 0, reg_rmo = 64'h0000_0000_0400_0000;
  logic [1:0]  req_kind = 0;
  logic st_hv = 0, st_ir = 0, st_dr = 0, st_vhyp = 0, cfg_hv_impl = 1;
  logic [PARTW-1:0] reg_part = 12'h5A5;
  logic [PROCW-1:0] reg_proc = 20'h00123;
  logic [4:0] cfg_prts = 5'd1;
  logic [4:0] rsp_outcome;
  logic [63:0] rsp_raddr, rsp_fault_addr;
  logic [2:0] rsp_perm;
  logic [PARTW-1:0] rsp_part;
  logic [PROCW-1:0] rsp_proc;
  logic rsp_ifetch;

  xlat_ctx_sel #(.PARTW(PARTW), .PROCW(PROCW)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_ea, .req_kind, .st_hv,
    .st_ir, .st_dr, .st_vhyp, .cfg_hv_impl, .reg_part, .reg_proc, .reg_rmo,
    .cfg_prts, .rsp_valid, .rsp_ready, .rsp_outcome, .rsp_raddr, .rsp_perm,
    .rsp_part, .rsp_proc, .rsp_ifetch, .rsp_fault_addr
  );

  int errs = 0, checks = 0;

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [63:0] ea;
    logic [1:0]  kind;
    logic hv, ir, dr, vhv, himpl;
    logic [4:0]  prts;
    logic [4:0]  oc;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1, O_BYP}, // R2 R3
    '{64'h8000_0000_0000_2000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1, O_BYP}, // R3 bit63
    '{64'hF123_4567_89AB_CDEF, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1, O_BYP}, // R3 no offset
    '{64'h7000_0000_0000_0010, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd1, O_BYP}, // R3 no hv impl
    '{64'h0000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R5 q0
    '{64'h4000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R5 q1
    '{64'h8000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R5 q2
    '{64'hC000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R5 q3
    '{64'h0000_0000_0000_0200, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R6 q0
    '{64'hC000_0000_0000_0200, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R6 q3
    '{64'h4000_0000_0000_0300, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_SEG}, // R7 data
    '{64'h8000_0000_0000_0300, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_SEG}, // R7 fetch
    '{64'h0000_0000_0000_0400, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, O_XLT}, // R2 no hv
    '{64'h0000_0000_0000_0500, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0, O_NOE}, // R8
    '{64'h8000_0000_0000_0500, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0, O_XLT}, // R8 proc 0
    '{64'h0000_0000_0000_0600, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, O_CFG}, // R1
    '{64'h0000_0000_0000_0700, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT}, // R2 ir vs dr
    '{64'h4000_0000_0000_0800, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd1, O_BYP}  // R9 priority
  };

  // independent reference from the requirements
  typedef struct packed {
    logic [4:0] oc; logic [63:0] ra; logic [2:0] perm;
    logic [PARTW-1:0] part; logic [PROCW-1:0] proc;
    logic ifx; logic [63:0] fa;
  } exp_t;

  function automatic exp_t model(input vec_t v, input logic [PROCW-1:0] pr);
    exp_t e = '0;
    logic reloc;
    logic [PARTW-1:0] pt;
    logic [PROCW-1:0] pc;
    logic ok;
    logic [63:0] off, sz;
    reloc = (v.kind == 2'd2) ? v.ir : v.dr;
    ok = 1'b1; pt = '0; pc = '0;
    case (v.ea[63:62])
      2'd0: begin pt = v.hv ? '0 : reg_part; pc = pr; end
      2'd1: if (v.hv) begin pt = reg_part; pc = pr; end else ok = 1'b0;
      2'd2: if (v.hv) pt = reg_part; else ok = 1'b0;
      default: pt = v.hv ? '0 : reg_part;
    endcase
    off = 64'(pc) * 64'd16;
    sz  = 64'd1 << (v.prts + 12);
    if (v.kind == 2'd3) e.oc = O_CFG;
    else if ((v.hv || v.vhv) && !reloc) begin
      e.oc = O_BYP; e.perm = 3'b111;
      e.ra = {4'h0, v.ea[59:0]};
      if ((v.hv || !v.himpl) && !v.ea[63]) e.ra = e.ra | reg_rmo;
    end else if (!ok || off >= sz) begin
      e.oc = ok ? O_NOE : O_SEG;
      e.ifx = (v.kind == 2'd2);
      e.fa = e.ifx ? 64'd0 : v.ea;
    end else begin
      e.oc = O_XLT; e.part = pt; e.proc = pc;
    end
    return e;
  endfunction

  function automatic string tag(input logic [4:0] oc);
    case (oc)
      O_BYP: return "R2 R3 R4";
      O_SEG: return "R7";
      O_NOE: return "R8";
      O_XLT: return "R5 R6";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input vec_t v);
    req_ea = v.ea; req_kind = v.kind; st_hv = v.hv; st_ir = v.ir;
    st_dr = v.dr; st_vhyp = v.vhv; cfg_hv_impl = v.himpl; cfg_prts = v.prts;
  endtask

  task automatic verify(input vec_t v, input logic [4:0] exp_oc);
    exp_t e = model(v, reg_proc);
    check(rsp_valid, "R10 valid", 64'(rsp_valid), 64'd1);
    check(rsp_outcome == exp_oc && e.oc == exp_oc, {"R9 outcome ", tag(exp_oc)},
          64'(rsp_outcome), 64'(exp_oc));
    check(rsp_raddr == e.ra, "R3 raddr", rsp_raddr, e.ra);
    check(rsp_perm == e.perm, "R4 perm", 64'(rsp_perm), 64'(e.perm));
    check(rsp_part == e.part && rsp_proc == e.proc, {"ids ", tag(exp_oc)},
          {rsp_part, rsp_proc}, {e.part, e.proc});
    check(rsp_ifetch == e.ifx && rsp_fault_addr == e.fa, {"fault ", tag(exp_oc)},
          rsp_fault_addr, e.fa);
  endtask

  initial begin : watchdog
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!rsp_valid, "R11 valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R11 ready", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      verify(VECS[i], VECS[i].oc);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(!rsp_valid, "R10 drain", 64'(rsp_valid), 64'd0);

    // R8 boundary: 0xFF*16 = 0xFF0 < 4096, 0x100*16 = 4096 not below
    v = '{64'h0000_0000_0000_0010, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0, O_XLT};
    reg_proc = 20'h000FF; apply(v); req_valid = 1'b1;
    @(negedge clk);
    verify(v, O_XLT);
    reg_proc = 20'h00100;
    @(negedge clk);
    verify(v, O_NOE);

    // R10: back-pressure holds the result and blocks new requests
    reg_proc = 20'h00123;
    v = '{64'h0000_0000_0000_0020, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1, O_XLT};
    apply(v);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_ea = 64'h4000_0000_0000_0000; st_hv = 1'b0; // would be a segment fault
    @(negedge clk);
    check(!req_ready, "R10 ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    verify(v, O_XLT);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_outcome == O_SEG, "R10 R7 after release", 64'(rsp_outcome), 64'(O_SEG));
    req_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule